// File: doc/BRIEF.md
# Range-Matched Fully Associative Translation Buffer

This block holds a small set of address translations, each described by a virtual window (a first and a last virtual address), a physical page number, a valid flag and a packed protection word. A lookup carries a virtual address, a privilege index and an access kind. One cycle later the block reports a hit or a miss, the physical address and the raw protection word. It does not judge rights itself: a protection checker further down the pipeline decodes the word. A reserved privilege index selects untranslated operation. In that mode the address passes through unchanged with full rights.

Software keeps the buffer up to date with four commands. A translation is installed in two steps. First an address command claims a slot and records the window and the physical page. Then a protection command fills in the rights and arms the slot. A page purge drops one translation and a global purge drops them all. When no slot already covers the new address, slots are claimed round-robin. Any stale slot that covers the new address is dropped before the new one is written.

Top module: `range_tlb`

## Requirements
- R1: A lookup hits a slot when the slot's first address is at or below the lookup address and the lookup address is at or below the slot's last address. When several slots qualify, the lowest index is used.
- R2: A lookup reports a miss when no window covers the address or the covering slot is not valid. The miss appears on `rsp_itlb_miss_o` when the access kind is execute (code 2). It appears on `rsp_dtlb_miss_o` for read (0) and write (1). Exactly one of hit, instruction miss and data miss is high with each response.
- R3: When the privilege index equals `PHYS_IDX` (default 4), the response is a hit, the physical address equals the virtual address and `rsp_rwx_o` is 3'b111. In every other response `rsp_rwx_o` is 3'b000.
- R4: On a translated hit, the physical address is the slot's page number above bits [11:0] of the virtual address. `rsp_prot_o` carries the slot's protection word.
- R5: An address command (op 0) first drops every valid slot whose window covers the command address. It then writes into the lowest-index covering slot, if one exists, and leaves the round-robin pointer where it is.
- R6: When no slot covers the address, an address command writes the slot named by the round-robin pointer. The pointer then advances by one and wraps to 0 after the last slot.
- R7: An address command sets the window to the 4 KiB page holding the address: the first address is page-aligned and the last is first plus 4095. The page number is taken from data bits [24:5]. The slot stays not valid, so lookups to it miss.
- R8: A protection command (op 1) finds the covering slot by address. It stores data bits [29:1] as the protection word and marks the slot valid.
- R9: A protection command that finds no covering slot changes no slot and sets `err_o`. `err_o` stays set until reset.
- R10: A page purge (op 2) drops the covering slot only if it is valid. A global purge (op 3) drops every slot. Neither command moves the round-robin pointer.
- R11: A dropped slot has its first address set to all ones and its last address set to zero. No lookup address, including all ones, can hit it.
- R12: A lookup accepted at a clock edge produces a response, with `rsp_valid_o` high, for the following cycle only. When a command strobe and a lookup strobe arrive in the same cycle, the command is executed and the lookup is dropped with no response.
- R13: After reset every slot is dropped, the round-robin pointer is 0, `err_o` is low and no response is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 2 | 0 insert address, 1 insert protection, 2 purge page, 3 purge all |
| cmd_va_i | input | 32 | Virtual address operand of the command |
| cmd_data_i | input | 32 | Data word: page number in [24:5], protection in [29:1] |
| lkp_valid_i | input | 1 | Lookup strobe |
| lkp_va_i | input | 32 | Lookup virtual address |
| lkp_priv_i | input | 3 | Privilege index; `PHYS_IDX` bypasses translation |
| lkp_acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid_o | output | 1 | Response present this cycle |
| rsp_hit_o | output | 1 | Translation found or bypassed |
| rsp_itlb_miss_o | output | 1 | Miss on an execute access |
| rsp_dtlb_miss_o | output | 1 | Miss on a read or write access |
| rsp_pa_o | output | 32 | Physical address |
| rsp_prot_o | output | 29 | Protection word of the hit slot, zero otherwise |
| rsp_rwx_o | output | 3 | Rights granted in bypass mode (read, write, execute) |
| err_o | output | 1 | Sticky flag: protection insert with no covering slot |

## Verification
Software maintenance and translation can land on the same clock edge. The bench provokes this by raising a page purge and a lookup of that same page together. It judges the result by the absent response in the next cycle and by the miss returned when the page is looked up again afterwards. Slot reuse and round-robin eviction are judged only through lookups: which page still hits after the ninth install, and which one after a re-install of a resident page, shows where each write landed.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;
  typedef enum logic [1:0] {
    CMD_INS_ADDR   = 2'd0,
    CMD_INS_PROT   = 2'd1,
    CMD_PURGE_PAGE = 2'd2,
    CMD_PURGE_ALL  = 2'd3
  } cmd_op_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  localparam int DATA_W   = 32;
  localparam int PPN_LSB  = 5;
  localparam int PPN_W    = 20;
  localparam int PROT_LSB = 1;
  localparam int PROT_W   = 29;
endpackage

// File: rtl/range_tlb_match.sv
module range_tlb_match #(
  parameter int N     = 8,
  parameter int VA_W  = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [VA_W-1:0]         va_i,
  input  logic [N-1:0][VA_W-1:0]  beg_i,
  input  logic [N-1:0][VA_W-1:0]  end_i,
  output logic [N-1:0]            cover_o,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign cover_o[g] = (beg_i[g] <= va_i) && (va_i <= end_i[g]);
  end

  assign any_o = |cover_o;

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cover_o[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/range_tlb_rr.sv
module range_tlb_rr #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IDX_W'(N - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int VA_W      = 32,
  parameter int PG_OFS_W  = 12,
  parameter int PRIV_W    = 3,
  parameter int PHYS_IDX  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [VA_W-1:0]   cmd_va_i,
  input  logic [DATA_W-1:0] cmd_data_i,
  input  logic              lkp_valid_i,
  input  logic [VA_W-1:0]   lkp_va_i,
  input  logic [PRIV_W-1:0] lkp_priv_i,
  input  logic [1:0]        lkp_acc_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_itlb_miss_o,
  output logic              rsp_dtlb_miss_o,
  output logic [PPN_W+PG_OFS_W-1:0] rsp_pa_o,
  output logic [PROT_W-1:0] rsp_prot_o,
  output logic [2:0]        rsp_rwx_o,
  output logic              err_o
);
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam int PA_W  = PPN_W + PG_OFS_W;

  logic [N_ENTRIES-1:0][VA_W-1:0]   beg_q, end_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [N_ENTRIES-1:0][PROT_W-1:0] prot_q;
  logic [N_ENTRIES-1:0]             vld_q;

  logic [N_ENTRIES-1:0] lkp_cover, cmd_cover;
  logic                 lkp_any, cmd_any;
  logic [IDX_W-1:0]     lkp_idx, cmd_idx, rr_ptr, victim;
  logic                 rr_adv;
  logic [VA_W-1:0]      pg_base;

  range_tlb_match #(.N(N_ENTRIES), .VA_W(VA_W), .IDX_W(IDX_W)) u_lkp_match (
    .va_i(lkp_va_i), .beg_i(beg_q), .end_i(end_q),
    .cover_o(lkp_cover), .any_o(lkp_any), .idx_o(lkp_idx)
  );

  range_tlb_match #(.N(N_ENTRIES), .VA_W(VA_W), .IDX_W(IDX_W)) u_cmd_match (
    .va_i(cmd_va_i), .beg_i(beg_q), .end_i(end_q),
    .cover_o(cmd_cover), .any_o(cmd_any), .idx_o(cmd_idx)
  );

  assign rr_adv = cmd_valid_i && (cmd_op_e'(cmd_op_i) == CMD_INS_ADDR) && !cmd_any;

  range_tlb_rr #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_rr (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(rr_adv), .ptr_o(rr_ptr)
  );

  assign victim  = cmd_any ? cmd_idx : rr_ptr;
  assign pg_base = {cmd_va_i[VA_W-1:PG_OFS_W], {PG_OFS_W{1'b0}}};

  // slot state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beg_q  <= '1;
      end_q  <= '0;
      ppn_q  <= '0;
      prot_q <= '0;
      vld_q  <= '0;
      err_o  <= 1'b0;
    end else if (cmd_valid_i) begin
      unique case (cmd_op_e'(cmd_op_i))
        CMD_INS_ADDR: begin
          for (int i = 0; i < N_ENTRIES; i++) begin
            if (cmd_cover[i] && vld_q[i]) begin
              beg_q[i] <= '1; end_q[i] <= '0; ppn_q[i] <= '0;
              prot_q[i] <= '0; vld_q[i] <= 1'b0;
            end
          end
          beg_q[victim]  <= pg_base;
          end_q[victim]  <= pg_base | {{(VA_W-PG_OFS_W){1'b0}}, {PG_OFS_W{1'b1}}};
          ppn_q[victim]  <= cmd_data_i[PPN_LSB +: PPN_W];
          prot_q[victim] <= '0;
          vld_q[victim]  <= 1'b0;
        end
        CMD_INS_PROT: begin
          if (cmd_any) begin
            prot_q[cmd_idx] <= cmd_data_i[PROT_LSB +: PROT_W];
            vld_q[cmd_idx]  <= 1'b1;
          end else begin
            err_o <= 1'b1;
          end
        end
        CMD_PURGE_PAGE: begin
          if (cmd_any && vld_q[cmd_idx]) begin
            beg_q[cmd_idx] <= '1; end_q[cmd_idx] <= '0; ppn_q[cmd_idx] <= '0;
            prot_q[cmd_idx] <= '0; vld_q[cmd_idx] <= 1'b0;
          end
        end
        CMD_PURGE_ALL: begin
          beg_q  <= '1;
          end_q  <= '0;
          ppn_q  <= '0;
          prot_q <= '0;
          vld_q  <= '0;
        end
        default: ;
      endcase
    end
  end

  // lookup result
  logic              byp, tr_hit, hit_d, accept;
  logic [PA_W-1:0]   pa_d;
  logic [PROT_W-1:0] prot_d;

  assign accept = lkp_valid_i && !cmd_valid_i;
  assign byp    = lkp_priv_i == PRIV_W'(PHYS_IDX);
  assign tr_hit = lkp_any && vld_q[lkp_idx];
  assign hit_d  = byp || tr_hit;

  always_comb begin
    pa_d   = '0;
    prot_d = '0;
    if (byp) begin
      pa_d = PA_W'(lkp_va_i);
    end else if (tr_hit) begin
      pa_d   = {ppn_q[lkp_idx], lkp_va_i[PG_OFS_W-1:0]};
      prot_d = prot_q[lkp_idx];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o     <= 1'b0;
      rsp_hit_o       <= 1'b0;
      rsp_itlb_miss_o <= 1'b0;
      rsp_dtlb_miss_o <= 1'b0;
      rsp_pa_o        <= '0;
      rsp_prot_o      <= '0;
      rsp_rwx_o       <= '0;
    end else begin
      rsp_valid_o     <= accept;
      rsp_hit_o       <= accept && hit_d;
      rsp_itlb_miss_o <= accept && !hit_d && (acc_e'(lkp_acc_i) == ACC_EXEC);
      rsp_dtlb_miss_o <= accept && !hit_d && (acc_e'(lkp_acc_i) != ACC_EXEC);
      rsp_pa_o        <= accept ? pa_d : '0;
      rsp_prot_o      <= accept ? prot_d : '0;
      rsp_rwx_o       <= (accept && byp) ? 3'b111 : 3'b000;
    end
  end
endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk
  import range_tlb_pkg::*;
#(
  parameter int VA_W     = 32,
  parameter int PG_OFS_W = 12,
  parameter int PRIV_W   = 3,
  parameter int PHYS_IDX = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              lkp_valid_i,
  input logic [VA_W-1:0]   lkp_va_i,
  input logic [PRIV_W-1:0] lkp_priv_i,
  input logic [1:0]        lkp_acc_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic              rsp_itlb_miss_o,
  input logic              rsp_dtlb_miss_o,
  input logic [PPN_W+PG_OFS_W-1:0] rsp_pa_o,
  input logic [2:0]        rsp_rwx_o,
  input logic              err_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  p_rsp_timing_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (rsp_valid_o == $past(lkp_valid_i && !cmd_valid_i)));

  p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> !(rsp_hit_o || rsp_itlb_miss_o || rsp_dtlb_miss_o));

  p_one_outcome_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $countones({rsp_hit_o, rsp_itlb_miss_o, rsp_dtlb_miss_o}) == 1);

  p_imiss_exec_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rsp_itlb_miss_o) |-> $past(lkp_acc_i) == 2'd2);

  p_bypass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rsp_valid_o && $past(lkp_priv_i) == PRIV_W'(PHYS_IDX))
      |-> (rsp_hit_o && rsp_rwx_o == 3'b111 && rsp_pa_o == $past(lkp_va_i)));

  p_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && rsp_hit_o) |-> rsp_pa_o[PG_OFS_W-1:0] == $past(lkp_va_i[PG_OFS_W-1:0]));

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
endmodule

bind range_tlb range_tlb_chk #(
  .VA_W(VA_W), .PG_OFS_W(PG_OFS_W), .PRIV_W(PRIV_W), .PHYS_IDX(PHYS_IDX)
) u_chk (.*);

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = '0;
  logic [31:0] cmd_va = '0, cmd_data = '0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_va = '0;
  logic [2:0]  lkp_priv = '0;
  logic [1:0]  lkp_acc = '0;
  logic        rsp_valid, rsp_hit, rsp_im, rsp_dm, err;
  logic [31:0] rsp_pa;
  logic [28:0] rsp_prot;
  logic [2:0]  rsp_rwx;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  range_tlb u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_va_i(cmd_va), .cmd_data_i(cmd_data),
    .lkp_valid_i(lkp_valid), .lkp_va_i(lkp_va), .lkp_priv_i(lkp_priv), .lkp_acc_i(lkp_acc),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_itlb_miss_o(rsp_im),
    .rsp_dtlb_miss_o(rsp_dm), .rsp_pa_o(rsp_pa), .rsp_prot_o(rsp_prot),
    .rsp_rwx_o(rsp_rwx), .err_o(err)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [2:0]  priv;
    logic [1:0]  acc;
    logic        hit, im, dm;
    logic [31:0] pa;
    logic [2:0]  rwx;
  } vec_t;

  localparam vec_t VEC[8] = '{
    '{32'h0001_0000, 3'd0, 2'd0, 1'b1, 1'b0, 1'b0, 32'h00AB_C000, 3'd0},
    '{32'h0001_0FFF, 3'd1, 2'd1, 1'b1, 1'b0, 1'b0, 32'h00AB_CFFF, 3'd0},
    '{32'h0001_1000, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 3'd0},
    '{32'h0001_1000, 3'd0, 2'd2, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 3'd0},
    '{32'h2000_3123, 3'd2, 2'd2, 1'b1, 1'b0, 1'b0, 32'h1234_5123, 3'd0},
    '{32'h0000_FFFF, 3'd0, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 3'd0},
    '{32'hDEAD_BEEF, 3'd4, 2'd1, 1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF, 3'd7},
    '{32'hFFFF_FFFF, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 32'h0000_0000, 3'd0}
  };

  localparam logic [31:0] PROT_A = 32'h1B5F_0A42;
  localparam logic [31:0] PROT_B = 32'h2C00_1236;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [1:0] op, input logic [31:0] va, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_va = va; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_lkp(input logic [31:0] va, input logic [2:0] priv, input logic [1:0] acc);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_va = va; lkp_priv = priv; lkp_acc = acc;
    @(negedge clk);
    lkp_valid = 1'b0;
  endtask

  function automatic logic [31:0] pdat(input logic [19:0] ppn);
    return {7'b0, ppn, 5'b0};
  endfunction

  task automatic map(input logic [31:0] va, input logic [19:0] ppn, input logic [31:0] pw);
    do_cmd(2'd0, va, pdat(ppn));
    do_cmd(2'd1, va, pw);
  endtask

  task automatic expect_miss(input string req, input logic [31:0] va);
    do_lkp(va, 3'd0, 2'd0);
    chk(req, {rsp_valid, rsp_hit, rsp_dm}, 3'b101);
  endtask

  task automatic expect_hit(input string req, input logic [31:0] va, input logic [31:0] pa);
    do_lkp(va, 3'd0, 2'd0);
    chk(req, {rsp_valid, rsp_hit, rsp_pa}, {2'b11, pa});
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R13 reset rsp_valid", rsp_valid, 0);
    chk("R13 reset err", err, 0);
    expect_miss("R13 empty after reset", 32'h0001_0000);

    map(32'h0001_0000, 20'h00ABC, PROT_A);
    map(32'h2000_3000, 20'h12345, PROT_B);

    // R1 R2 R3 R4 R11 table
    for (int i = 0; i < 8; i++) begin
      do_lkp(VEC[i].va, VEC[i].priv, VEC[i].acc);
      chk($sformatf("R1 R2 R3 R11 vec%0d outcome", i),
          {rsp_valid, rsp_hit, rsp_im, rsp_dm}, {1'b1, VEC[i].hit, VEC[i].im, VEC[i].dm});
      chk($sformatf("R3 R4 vec%0d pa", i), rsp_pa, VEC[i].pa);
      chk($sformatf("R3 vec%0d rwx", i), rsp_rwx, VEC[i].rwx);
    end

    do_lkp(32'h0001_0234, 3'd0, 2'd0);
    chk("R8 prot word A", rsp_prot, PROT_A[29:1]);
    do_lkp(32'h2000_3FFF, 3'd0, 2'd1);
    chk("R8 prot word B", rsp_prot, PROT_B[29:1]);

    // R7 address-only install stays invalid
    do_cmd(2'd0, 32'h3000_0ABC, pdat(20'h55555));
    expect_miss("R7 invalid until protection", 32'h3000_0000);
    do_cmd(2'd1, 32'h3000_0010, PROT_B);
    expect_hit("R7 window last byte", 32'h3000_0FFF, 32'h5555_5FFF);
    expect_miss("R7 window ends at page", 32'h3000_1000);

    // R9 orphan protection insert
    chk("R9 err low before", err, 0);
    do_cmd(2'd1, 32'h7777_0000, PROT_A);
    chk("R9 err set", err, 1);
    expect_miss("R9 no slot created", 32'h7777_0000);
    do_lkp(32'h0001_0000, 3'd0, 2'd0);
    chk("R9 other slot untouched", {rsp_hit, rsp_prot}, {1'b1, PROT_A[29:1]});

    // R12 command and lookup in the same cycle
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'd2; cmd_va = 32'h2000_3000;
    lkp_valid = 1'b1; lkp_va = 32'h2000_3000; lkp_priv = 3'd0; lkp_acc = 2'd0;
    @(negedge clk);
    cmd_valid = 1'b0; lkp_valid = 1'b0;
    chk("R12 lookup dropped", {rsp_valid, rsp_hit}, 2'b00);
    expect_miss("R10 R12 purge page done", 32'h2000_3000);
    do_cmd(2'd2, 32'h5000_0000, 32'h0);
    expect_hit("R10 purge of unmapped page", 32'h0001_0004, 32'h00AB_C004);

    do_cmd(2'd3, 32'h0, 32'h0);
    expect_miss("R10 purge all A", 32'h0001_0000);
    expect_miss("R10 purge all C", 32'h3000_0000);

    // R6 round-robin wrap: nine new pages into eight slots
    for (int k = 0; k < 9; k++)
      map(32'h4000_0000 + 32'(k) * 32'h1000, 20'h00100 + 20'(k), PROT_A);
    expect_miss("R6 oldest evicted", 32'h4000_0000);
    expect_hit("R6 next survives", 32'h4000_1008, 32'h0010_1008);

    // R5 reinstall of resident page reuses its slot, pointer unmoved
    do_cmd(2'd0, 32'h4000_1000, pdat(20'h00999));
    expect_miss("R5 old copy dropped", 32'h4000_1000);
    do_cmd(2'd1, 32'h4000_1000, PROT_A);
    expect_hit("R5 new page number", 32'h4000_1ABC, 32'h0099_9ABC);
    map(32'h4000_9000, 20'h00200, PROT_A);
    expect_miss("R5 R6 pointer not advanced by reuse", 32'h4000_1000);
    expect_hit("R5 R6 neighbour kept", 32'h4000_2000, 32'h0010_2000);

    chk("R9 err still set", err, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule